// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and a calendar date in packed BCD. A one-second tick is derived by counting pulses of a slow reference enable, normally 32,768 pulses per second, and each tick advances seconds, minutes, hours, day of month, weekday, month and a two-digit year, with a century bit that flips when the year wraps. A day of month knows the month lengths and the leap years of the two-digit year.

Software reaches the block through a byte-wide register port with an internal address pointer. A start strobe loads the pointer, and every write or read-advance strobe moves it on by one, so that the whole time can be loaded or fetched in one seven-byte run. To load a new time, software first sets the freeze bit in the control byte, writes the calendar bytes and then clears the freeze bit. The first second after that counts in full. A validity flag comes up at reset and marks the held time as untrustworthy until software writes a seconds value with that flag clear.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the registers read: control (address 0x00) 0x00, seconds (0x02) 0x80, minutes (0x03) 0x00, hours (0x04) 0x00, day (0x05) 0x01, weekday (0x06) 0x00, month (0x07) 0x01, year (0x08) 0x00.
- R2: While the freeze bit (bit 5 of the control byte at 0x00) is 1, no calendar field changes except by a bus write. After it is cleared, counting resumes.
- R3: The validity flag is bit 7 of the seconds byte. It is 1 after reset, it takes the value of bit 7 whenever the seconds byte is written, and it does not change otherwise.
- R4: Seconds and minutes count 0x00 to 0x59 and hours count 0x00 to 0x23 in BCD. The low digit carries into the high digit after 9, and each wrap carries into the next field.
- R5: The day of month counts from 0x01 to the month's last day: 0x28 in February, or 0x29 when the binary value of the year is divisible by 4. The last day is 0x30 in April, June, September and November and 0x31 in every other month.
- R6: The weekday (0 to 6) moves on once each time the day of month moves on, and wraps from 6 to 0.
- R7: The month counts 0x01 to 0x12 and the year counts 0x00 to 0x99. The century bit is bit 7 of the month byte, and it toggles when the year wraps from 0x99 to 0x00.
- R8: Writes keep only the field bits: control bit 5, seconds [7:0], minutes [6:0], hours [5:0], day [5:0], weekday [2:0], month bits 7 and [4:0], and year [7:0]. Every other bit reads 0. The byte at 0x01 and the addresses 0x09 to 0x0F always read 0.
- R9: One second lasts PRESCALE reference pulses. While frozen, the pulse count is held at zero, so the first advance comes exactly PRESCALE pulses after the freeze bit is cleared.
- R10: Address 0x02 through 0x08 hold seconds, minutes, hours, day, weekday, month and year in that order. The pointer steps by one after each write and each read-advance, so that a seven-byte run starting at 0x02 covers the whole time.
- R11: A one-second tick that falls in a cycle with a bus write is dropped, and no field advances in that cycle.
- R12: A field that holds a value at or beyond its last legal value wraps to its first value on the next advance and carries into the next field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-cycle reference pulse (e.g. 32.768 kHz rate) |
| bus_start | input | 1 | Loads the pointer from bus_addr; access in the same cycle uses bus_addr |
| bus_addr | input | 4 | Register address for a start strobe |
| bus_we | input | 1 | Write strobe: stores bus_wdata, then steps the pointer |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read-advance strobe: steps the pointer |
| bus_rdata | output | 8 | Byte at the current pointer |

## Verification
A wrong carry or wrap decision shows up at the ports one second after the boundary it concerns. A wrong seconds wrap appears in the next tick, but a wrong month length or leap decision shows only at the end of the month concerned. For this reason the bench loads each month-end directly instead of waiting for it, and sweeps every month over sixteen years. A prescaler that is not cleared by the freeze bit does not show in the time value. It shows only as a first second that comes early after release, so that timing is checked with single reference pulses. A lost or extra validity-flag update shows at once in the next read of the seconds byte.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam logic [3:0] ADR_CTRL  = 4'h0;
  localparam logic [3:0] ADR_AUX   = 4'h1;
  localparam logic [3:0] ADR_SEC   = 4'h2;
  localparam logic [3:0] ADR_MIN   = 4'h3;
  localparam logic [3:0] ADR_HOUR  = 4'h4;
  localparam logic [3:0] ADR_DAY   = 4'h5;
  localparam logic [3:0] ADR_WDAY  = 4'h6;
  localparam logic [3:0] ADR_MON   = 4'h7;
  localparam logic [3:0] ADR_YEAR  = 4'h8;
  localparam int         NUM_REGS  = 9;
  localparam int         FREEZE_BIT = 5;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] day;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [7:0] year;
    logic       cent;
  } cal_t;

  typedef struct packed {
    logic [7:0] val;
    logic       wrap;
  } step_t;

  // Advance one BCD field; values at or past the limit wrap to 'first'.
  function automatic step_t bcd_step(input logic [7:0] v,
                                     input logic [7:0] last,
                                     input logic [7:0] first);
    step_t r;
    r.wrap = 1'b0;
    if (v >= last) begin
      r.val  = first;
      r.wrap = 1'b1;
    end else if (v[3:0] >= 4'd9) begin
      r.val = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r.val = v + 8'd1;
    end
    return r;
  endfunction

  // Binary value of a two-digit BCD year divisible by four.
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_end(input logic [4:0] m,
                                           input logic [7:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic hold,
  output logic sec_tick
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last  = (cnt_q == CNT_LAST);
  assign sec_tick = ref_tick && !hold && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (hold)          cnt_d = '0;
    else if (ref_tick) cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_HOLD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
  import rtc_cal_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  step_t st_sec, st_min, st_hour, st_day, st_wday, st_mon, st_year;
  logic  cy_min, cy_hour, cy_day, cy_mon, cy_year;

  always_comb begin
    st_sec  = bcd_step({1'b0, cur.sec},  8'h59, 8'h00);
    st_min  = bcd_step({1'b0, cur.min},  8'h59, 8'h00);
    st_hour = bcd_step({2'b0, cur.hour}, 8'h23, 8'h00);
    st_day  = bcd_step({2'b0, cur.day},  month_end(cur.mon, cur.year), 8'h01);
    st_wday = bcd_step({5'b0, cur.wday}, 8'h06, 8'h00);
    st_mon  = bcd_step({3'b0, cur.mon},  8'h12, 8'h01);
    st_year = bcd_step(cur.year,         8'h99, 8'h00);

    cy_min  = st_sec.wrap;
    cy_hour = cy_min  && st_min.wrap;
    cy_day  = cy_hour && st_hour.wrap;
    cy_mon  = cy_day  && st_day.wrap;
    cy_year = cy_mon  && st_mon.wrap;

    nxt      = cur;
    nxt.sec  = st_sec.val[6:0];
    if (cy_min)  nxt.min  = st_min.val[6:0];
    if (cy_hour) nxt.hour = st_hour.val[5:0];
    if (cy_day) begin
      nxt.day  = st_day.val[5:0];
      nxt.wday = st_wday.val[2:0];
    end
    if (cy_mon)  nxt.mon  = st_mon.val[4:0];
    if (cy_year) begin
      nxt.year = st_year.val;
      nxt.cent = cur.cent ^ st_year.wrap;
    end
  end

endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port #(
  parameter int NREG = 9,
  parameter int AW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_start,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_rd,
  input  logic [NREG-1:0][7:0] rd_vec,
  output logic [NREG-1:0]      wr_sel,
  output logic [7:0]           bus_rdata
);
  logic [AW-1:0] ptr_q, ptr_d, eff_addr;

  assign eff_addr = bus_start ? bus_addr : ptr_q;

  always_comb begin
    ptr_d = eff_addr;
    if (bus_we || bus_rd) ptr_d = eff_addr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = bus_we && (eff_addr == AW'(g));
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (ptr_q == AW'(i)) bus_rdata = rd_vec[i];
    end
  end

  AST_POINTER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_start) |=> (ptr_q == AW'($past(ptr_q) + AW'(1)))); // R10

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       bus_start,
  input  logic [3:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cal_t                    cal_q, cal_d, cal_adv;
  logic                    freeze_q, freeze_d;
  logic                    invalid_q, invalid_d;
  logic                    sec_tick, adv_en, any_wr;
  logic [NUM_REGS-1:0]     wr_sel;
  logic [NUM_REGS-1:0][7:0] rd_vec;

  rtc_sec_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .ref_tick (ref_tick),
    .hold     (freeze_q),
    .sec_tick (sec_tick)
  );

  rtc_calendar_next u_next (
    .cur (cal_q),
    .nxt (cal_adv)
  );

  always_comb begin
    rd_vec           = '0;
    rd_vec[ADR_CTRL] = {2'b00, freeze_q, 5'b00000};
    rd_vec[ADR_AUX]  = 8'h00;
    rd_vec[ADR_SEC]  = {invalid_q, cal_q.sec};
    rd_vec[ADR_MIN]  = {1'b0, cal_q.min};
    rd_vec[ADR_HOUR] = {2'b00, cal_q.hour};
    rd_vec[ADR_DAY]  = {2'b00, cal_q.day};
    rd_vec[ADR_WDAY] = {5'b00000, cal_q.wday};
    rd_vec[ADR_MON]  = {cal_q.cent, 2'b00, cal_q.mon};
    rd_vec[ADR_YEAR] = cal_q.year;
  end

  rtc_reg_port #(.NREG(NUM_REGS), .AW(4)) u_port (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bus_start (bus_start),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rd    (bus_rd),
    .rd_vec    (rd_vec),
    .wr_sel    (wr_sel),
    .bus_rdata (bus_rdata)
  );

  assign any_wr = |wr_sel;
  assign adv_en = sec_tick && !any_wr;

  always_comb begin
    cal_d     = adv_en ? cal_adv : cal_q;
    freeze_d  = freeze_q;
    invalid_d = invalid_q;
    if (wr_sel[ADR_CTRL]) freeze_d = bus_wdata[FREEZE_BIT];
    if (wr_sel[ADR_SEC]) begin
      invalid_d = bus_wdata[7];
      cal_d.sec = bus_wdata[6:0];
    end
    if (wr_sel[ADR_MIN])  cal_d.min  = bus_wdata[6:0];
    if (wr_sel[ADR_HOUR]) cal_d.hour = bus_wdata[5:0];
    if (wr_sel[ADR_DAY])  cal_d.day  = bus_wdata[5:0];
    if (wr_sel[ADR_WDAY]) cal_d.wday = bus_wdata[2:0];
    if (wr_sel[ADR_MON]) begin
      cal_d.cent = bus_wdata[7];
      cal_d.mon  = bus_wdata[4:0];
    end
    if (wr_sel[ADR_YEAR]) cal_d.year = bus_wdata;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cal_q     <= '{sec: 7'h00, min: 7'h00, hour: 6'h00, day: 6'h01,
                     wday: 3'h0, mon: 5'h01, year: 8'h00, cent: 1'b0};
      freeze_q  <= 1'b0;
      invalid_q <= 1'b1;
    end else begin
      cal_q     <= cal_d;
      freeze_q  <= freeze_d;
      invalid_q <= invalid_d;
    end
  end

  AST_FROZEN_HOLDS_TIME: assert property (@(posedge clk) disable iff (!core_rst_n)
    (freeze_q && !bus_we) |=> $stable(cal_q)); // R2
  AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!core_rst_n)
    (invalid_q && !wr_sel[ADR_SEC]) |=> invalid_q); // R3
  AST_SECONDS_WRAP: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sec_tick && !any_wr && cal_q.sec == 7'h59) |=> (cal_q.sec == 7'h00)); // R4
  AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!core_rst_n)
    (any_wr && !wr_sel[ADR_SEC]) |=> $stable(cal_q.sec)); // R11

endmodule

// File: tb/bcd_calendar_core_tb_top.sv
module bcd_calendar_core_tb_top;
  localparam int PS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       bus_start = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  bcd_calendar_core #(.PRESCALE(PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_start = 1'b1; bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_start = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr_next(input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic point(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_start = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_start = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_next(output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    if (n > 0) begin
      @(negedge clk);
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, wd, mo, y);
    wr(4'h0, 8'h20);
    wr(4'h2, s);
    wr_next(mi); wr_next(h); wr_next(d); wr_next(wd); wr_next(mo); wr_next(y);
    wr(4'h0, 8'h00);
  endtask

  task automatic read_time(output logic [7:0] t [7]);
    logic [7:0] b;
    point(4'h2, b);
    t[0] = b;
    for (int i = 1; i < 7; i++) begin
      rd_next(b);
      t[i] = b;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] t [7];
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    point(4'h0, b); check("R1 ctrl", b, 8'h00);
    read_time(t);
    check("R1 time", {t[0], t[1], t[2], t[3]}, 32'h80000001);
    check("R1 date", {t[4], t[5], t[6]}, 24'h000100);

    // R3 validity flag
    wr(4'h2, 8'h92); point(4'h2, b); check("R3 flag kept", b, 8'h92);
    wr(4'h2, 8'h12); point(4'h2, b); check("R3 flag cleared", b, 8'h12);
    pulses(3 * PS); point(4'h2, b); check("R3 flag stays 0", b, 8'h15);

    // R8 field masks and dead addresses
    wr(4'h4, 8'hFF); point(4'h4, b); check("R8 hour mask", b, 8'h3F);
    wr(4'h6, 8'hFF); point(4'h6, b); check("R8 wday mask", b, 8'h07);
    wr(4'h7, 8'hFF); point(4'h7, b); check("R8 month mask", b, 8'h9F);
    wr(4'h3, 8'hFF); point(4'h3, b); check("R8 min mask", b, 8'h7F);
    wr(4'h5, 8'hFF); point(4'h5, b); check("R8 day mask", b, 8'h3F);
    wr(4'h1, 8'hFF); point(4'h1, b); check("R8 aux reads 0", b, 8'h00);
    wr(4'h9, 8'hFF); point(4'h9, b); check("R8 unmapped", b, 8'h00);
    wr(4'h0, 8'hFF); point(4'h0, b); check("R8 ctrl mask", b, 8'h20);
    wr(4'h0, 8'h00);

    // R12 out-of-range hour wraps and carries into day
    set_time(8'h59, 8'h59, 8'h3F, 8'h10, 8'h02, 8'h03, 8'h05);
    pulses(PS); read_time(t);
    check("R12 hour wrap", {t[0], t[1], t[2], t[3]}, 32'h00000011);

    // R9 prescaler timing and clear on freeze; R2 freeze
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    pulses(PS - 1); point(4'h2, b); check("R9 early", b, 8'h10);
    pulses(1);      point(4'h2, b); check("R9 one second", b, 8'h11);
    pulses(1);
    wr(4'h0, 8'h20);
    pulses(10 * PS); point(4'h2, b); check("R2 frozen", b, 8'h11);
    wr(4'h0, 8'h00);
    pulses(PS - 1); point(4'h2, b); check("R9 count cleared", b, 8'h11);
    pulses(1);      point(4'h2, b); check("R2 resumes", b, 8'h12);

    // R11 tick colliding with a write is dropped
    pulses(PS - 1);
    @(negedge clk);
    bus_start = 1'b1; bus_addr = 4'h1; bus_we = 1'b1; bus_wdata = 8'h00; ref_tick = 1'b1;
    @(negedge clk);
    bus_start = 1'b0; bus_we = 1'b0; ref_tick = 1'b0;
    point(4'h2, b); check("R11 dropped", b, 8'h12);
    pulses(PS); point(4'h2, b); check("R11 next second", b, 8'h13);

    // R10 burst read order after a burst write
    set_time(8'h07, 8'h16, 8'h21, 8'h14, 8'h05, 8'h09, 8'h42);
    read_time(t);
    check("R10 burst a", {t[0], t[1], t[2], t[3]}, 32'h07162114);
    check("R10 burst b", {t[4], t[5], t[6]}, 24'h050942);

    // R7 year wrap toggles century, R6 weekday wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
    pulses(PS); read_time(t);
    check("R7 century", {t[3], t[4], t[5], t[6]}, 32'h01008100);
    check("R6 wday wrap", t[4], 8'h00);

    // R5 R6 R7 month-end sweep over sixteen years
    for (int y = 0; y < 16; y++) begin
      for (int m = 1; m <= 12; m++) begin
        for (int d = 28; d <= 31; d++) begin
          int ed, em, ey, wd, ewd;
          wd = (m + d + y) % 7;
          ewd = (wd == 6) ? 0 : wd + 1;
          if (d >= days_in(m, y)) begin
            ed = 1;
            em = (m == 12) ? 1 : m + 1;
            ey = (m == 12) ? y + 1 : y;
          end else begin
            ed = d + 1; em = m; ey = y;
          end
          set_time(8'h59, 8'h59, 8'h23, bcd(d), bcd(wd), bcd(m), bcd(y));
          pulses(PS); read_time(t);
          check("R5 month end", {t[3], t[4], t[5], t[6]},
                {bcd(ed), bcd(ewd), bcd(em), bcd(ey)});
        end
      end
    end

    // R4 free run through ten hours in five-minute steps
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    for (int k = 1; k <= 121; k++) begin
      int ts;
      pulses(300 * PS);
      ts = k * 300;
      read_time(t);
      check("R4 clock run", {8'h00, t[2], t[1], t[0]},
            {8'h00, bcd(ts / 3600), bcd((ts / 60) % 60), bcd(ts % 60)});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule